// File: doc/BRIEF.md
# Programmable serial baud rate generator

This block turns a peripheral clock into the timing enables one serial channel needs. An 8-bit reload value N, a 2-bit prescaler select and a mode input set the rate. In asynchronous mode the block gives a one-cycle enable at sixteen times the bit rate. In clocked synchronous mode it gives a toggle enable for the serial clock, the serial clock itself, and a once-per-bit enable. Each serial channel has its own instance, so every channel runs at its own rate.

The rate is built in two stages. A free-running prescaler gives a pulse every P peripheral clocks, where P is 1, 8, 32 or 128. A down-counter of period N+1 counts those pulses and gives a half-period tick. Two ticks form one oversample period in asynchronous mode, or one serial clock half-period in synchronous mode. The asynchronous bit rate is therefore Pclk/(32·P·(N+1)) and the synchronous bit rate is Pclk/(4·P·(N+1)). The host can read and write the reload value at any time. A new reload value or a new prescaler select is picked up only when the counter next reloads.

Top module: `baud_gen`

## Requirements
- R1: After reset, rd_data reads 0xFF, sck_out is 1, and os_tick, sck_toggle and bit_en are 0.
- R2: A cycle with wr_en high stores wr_data in the reload register. From the following cycle, rd_data returns the stored value.
- R3: The prescaler select sets P: code 00 gives 1, 01 gives 8, 10 gives 32 and 11 gives 128 peripheral clocks per prescaler pulse.
- R4: With mode_sync = 0 and the block enabled, consecutive os_tick pulses are 2·P·(N+1) clock cycles apart. This is a bit period of 32·P·(N+1).
- R5: With mode_sync = 1, consecutive sck_toggle pulses are 2·P·(N+1) cycles apart. sck_out inverts on each one, starting from its idle level of 1, so the first toggle drives it low.
- R6: With mode_sync = 1, bit_en pulses once per serial clock period, on the toggle that returns sck_out to 1. Consecutive pulses are 4·P·(N+1) cycles apart.
- R7: In asynchronous mode, sck_toggle and bit_en stay 0 and sck_out stays 1. In synchronous mode, os_tick stays 0.
- R8: A change to the reload value or to the prescaler select does not shorten or lengthen the tick period in progress. The change takes effect from the next counter reload.
- R9: While en is 0, both counters are held cleared, os_tick, sck_toggle and bit_en are 0, and sck_out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Generator enable; low holds the counters cleared |
| mode_sync | input | 1 | 0 = asynchronous, 1 = clocked synchronous |
| cks | input | 2 | Prescaler select code |
| wr_en | input | 1 | Host write strobe for the reload register |
| wr_data | input | 8 | Host write data (N) |
| rd_data | output | 8 | Reload register read-back |
| os_tick | output | 1 | Sixteen-times oversample enable (asynchronous mode) |
| sck_toggle | output | 1 | Serial clock toggle enable (synchronous mode) |
| sck_out | output | 1 | Serial clock, idles high |
| bit_en | output | 1 | Once-per-bit enable (synchronous mode) |

## Verification
The assertions assume that mode_sync changes only while en is low. They also assume that cks changes at most once per tick period. The stimulus follows both rules: it drops en, changes the mode, N and the select, and then raises en again. The only mid-run changes are the single N write and the single select change that R8 tests, and each is made in the cycle after an os_tick. Pulse spacings are measured only after the first pulse following enable, because the first interval after enable is shorter by design.

// File: rtl/baud_pkg.sv
// Package: shared widths and the prescaler decode for the baud generator.
// Assumes: prescaler divides are powers of two no larger than 2**PRE_W.
package baud_pkg;
    localparam int N_W     = 8;
    localparam int CKS_W   = 2;
    localparam int PRE_W   = 7;

    // Terminal count of the prescaler (P-1) for a select code.
    function automatic logic [PRE_W-1:0] pre_limit(input logic [CKS_W-1:0] code);
        logic [PRE_W-1:0] lim;
        if (code == '0) begin
            lim = '0;
        end else begin
            lim = PRE_W'((1 << (2 * int'(code) + 1)) - 1);
        end
        return lim;
    endfunction
endpackage

// File: rtl/baud_prescaler.sv
// Module: free-running prescaler giving one pulse every P clocks.
// Assumes: cks_act changes only when the counter is at zero (at a reload).
module baud_prescaler
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CKS_W-1:0] cks_act,
    output logic             pre_pulse
);
    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] lim;

    // Decode the active select into a terminal count.
    always_comb lim = pre_limit(cks_act);

    // Emit the pulse on the terminal count.
    always_comb pre_pulse = en && (cnt == lim);

    // Count up and wrap at the terminal count; clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (pre_pulse) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0)); // R9
    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim); // R3
endmodule

// File: rtl/baud_reload_counter.sv
// Module: N+1 down-counter clocked by the prescaler pulse.
// At each reload it captures the reload value and the prescaler select, so a
// change never cuts short the period in progress.
// Assumes: n_reg and cks_in are quasi-static relative to the tick period.
module baud_reload_counter
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pre_pulse,
    input  logic [N_W-1:0]   n_reg,
    input  logic [CKS_W-1:0] cks_in,
    output logic             tick,
    output logic [CKS_W-1:0] cks_act
);
    logic [N_W-1:0] cnt;

    // A terminal tick is a prescaler pulse seen while the counter is at zero.
    always_comb tick = pre_pulse && (cnt == '0);

    // Decrement per prescaler pulse and reload at zero; track the select while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt     <= '0;
            cks_act <= cks_in;
        end else if (pre_pulse) begin
            if (cnt == '0) begin
                cnt     <= n_reg;
                cks_act <= cks_in;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(n_reg))); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !pre_pulse) |=> ($stable(cnt) && $stable(cks_act))); // R8
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0)); // R9
endmodule

// File: rtl/baud_phase.sv
// Module: pairs half-period ticks and routes them by mode.
// In asynchronous mode the pair pulse is the oversample enable. In
// synchronous mode it toggles the serial clock, and the toggle that
// returns the clock high marks a bit.
// Assumes: mode_sync changes only while en is low.
module baud_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mode_sync,
    input  logic tick,
    output logic os_tick,
    output logic sck_toggle,
    output logic sck_out,
    output logic bit_en
);
    logic pair;
    logic pair_pulse;

    // The second tick of each pair completes a period.
    always_comb pair_pulse = tick && pair;

    // Route the period pulse by mode.
    always_comb begin
        os_tick    = pair_pulse && !mode_sync;
        sck_toggle = pair_pulse && mode_sync;
        bit_en     = sck_toggle && !sck_out;
    end

    // Track the tick pair and the serial clock level; idle high.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pair    <= 1'b0;
            sck_out <= 1'b1;
        end else begin
            if (tick) begin
                pair <= ~pair;
            end
            if (sck_toggle) begin
                sck_out <= ~sck_out;
            end
        end
    end

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> sck_out); // R9
    AST_SCK_ASYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mode_sync) |=> $stable(sck_out)); // R7
    AST_BIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> sck_out); // R6
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        sck_toggle |=> (sck_out != $past(sck_out))); // R5
endmodule

// File: rtl/baud_gen.sv
// Module: top of the per-channel baud rate generator.
// It holds the host-visible reload register and chains the prescaler, the
// reload counter and the phase logic.
// Assumes: one instance per channel; wr_en is a single-cycle host strobe.
module baud_gen
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode_sync,
    input  logic [CKS_W-1:0] cks,
    input  logic             wr_en,
    input  logic [N_W-1:0]   wr_data,
    output logic [N_W-1:0]   rd_data,
    output logic             os_tick,
    output logic             sck_toggle,
    output logic             sck_out,
    output logic             bit_en
);
    logic [N_W-1:0]   n_reg;
    logic [CKS_W-1:0] cks_act;
    logic             pre_pulse;
    logic             tick;

    // Host reload register, reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_reg <= '1;
        end else if (wr_en) begin
            n_reg <= wr_data;
        end
    end

    // Read-back of the reload register.
    always_comb rd_data = n_reg;

    baud_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cks_act   (cks_act),
        .pre_pulse (pre_pulse)
    );

    baud_reload_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .pre_pulse (pre_pulse),
        .n_reg     (n_reg),
        .cks_in    (cks),
        .tick      (tick),
        .cks_act   (cks_act)
    );

    baud_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .mode_sync  (mode_sync),
        .tick       (tick),
        .os_tick    (os_tick),
        .sck_toggle (sck_toggle),
        .sck_out    (sck_out),
        .bit_en     (bit_en)
    );

    AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data))); // R2
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data)); // R2
    AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(os_tick && (sck_toggle || bit_en))); // R7
endmodule

// File: tb/tb_baud_gen.sv
module tb_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       mode_sync = 1'b0;
    logic [1:0] cks = 2'b00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       os_tick, sck_toggle, sck_out, bit_en;

    int n_checks = 0;
    int n_fail = 0;
    int bad_excl = 0;

    always #2 clk = ~clk;

    baud_gen dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_sync(mode_sync), .cks(cks),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .os_tick(os_tick), .sck_toggle(sck_toggle), .sck_out(sck_out),
        .bit_en(bit_en)
    );

    // Count pulses on the output that the current mode should keep quiet (R7).
    always @(negedge clk) begin
        if (en && rst_n) begin
            if (!mode_sync && (sck_toggle || bit_en || !sck_out)) bad_excl++;
            if (mode_sync && os_tick) bad_excl++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic pick(input int sel);
        case (sel)
            0: return os_tick;
            1: return sck_toggle;
            default: return bit_en;
        endcase
    endfunction

    // Wait for the next pulse on the selected output; return the cycles waited.
    task automatic wait_pulse(input int sel, output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!pick(sel) && cyc < 40000);
    endtask

    function automatic int pval(input int code);
        return (code == 0) ? 1 : (1 << (2 * code + 1));
    endfunction

    task automatic config_run(input int m, input int c, input int n);
        int cyc;
        @(negedge clk);
        en = 1'b0;
        mode_sync = m[0];
        cks = c[1:0];
        wr_en = 1'b1;
        wr_data = n[7:0];
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 readback", rd_data, n);
        check("R9 idle sck", sck_out, 1);
        bad_excl = 0;
        en = 1'b1;
        if (m == 0) begin
            wait_pulse(0, cyc);
            for (int i = 0; i < 2; i++) begin
                wait_pulse(0, cyc);
                check($sformatf("R4 R3 os period cks=%0d N=%0d", c, n), cyc, 2 * pval(c) * (n + 1));
            end
        end else begin
            wait_pulse(1, cyc);
            check("R5 first toggle low", sck_out, 1);
            for (int i = 0; i < 2; i++) begin
                wait_pulse(1, cyc);
                check($sformatf("R5 R3 sck period cks=%0d N=%0d", c, n), cyc, 2 * pval(c) * (n + 1));
            end
            wait_pulse(2, cyc);
            wait_pulse(2, cyc);
            check($sformatf("R6 bit period cks=%0d N=%0d", c, n), cyc, 4 * pval(c) * (n + 1));
        end
        check($sformatf("R7 exclusivity m=%0d", m), bad_excl, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int cyc;
        int nlist[4] = '{0, 1, 3, 7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset rd_data", rd_data, 8'hFF);
        check("R1 reset sck", sck_out, 1);
        check("R1 reset pulses", {os_tick, sck_toggle, bit_en}, 0);
        // R9 disabled: nothing happens over a long stretch
        repeat (50) @(negedge clk);
        check("R9 disabled pulses", {os_tick, sck_toggle, bit_en, sck_out}, 1);

        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 4; c++)
                for (int k = 0; k < 4; k++)
                    config_run(m, c, nlist[k]);
        config_run(0, 0, 255);

        // R8: change N in the cycle after an os_tick; the running period is kept.
        config_run(0, 0, 3);
        wait_pulse(0, cyc);
        wr_en = 1'b1;
        wr_data = 8'd9;
        @(negedge clk);
        wr_en = 1'b0;
        cyc = 1;
        while (!os_tick) begin @(negedge clk); cyc++; end
        check("R8 N change boundary", cyc, 4 + 10);
        wait_pulse(0, cyc);
        check("R8 N change steady", cyc, 20);
        // R8: change select in the cycle after an os_tick.
        @(negedge clk);
        cks = 2'b01;
        cyc = 1;
        while (!os_tick) begin @(negedge clk); cyc++; end
        check("R8 cks change boundary", cyc, 10 + 80);
        wait_pulse(0, cyc);
        check("R8 cks change steady", cyc, 160);

        // R9: dropping enable idles everything and restores sck high.
        config_run(1, 0, 2);
        wait_pulse(1, cyc);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R9 disable sck high", sck_out, 1);
        repeat (20) begin
            @(negedge clk);
            if (os_tick || sck_toggle || bit_en) bad_excl++;
        end
        check("R9 disable quiet", bad_excl, 0);
        summary();
    end
endmodule